// File: doc/BRIEF.md
# Memory Ordering Visibility Gate

This block holds memory operations that arrive in program order and decides when each one may become globally visible. An operation may overtake older ones except where the acquire, release and fence rules forbid it. Each operation carries a class, an address and a tag. The gate only decides when visibility happens: it does not model data values, caches or address overlap.

Entries sit in an age-ordered queue, with position 0 the oldest pending operation. On every cycle in which the memory side permits it (`grant_en`), the gate computes which entries are eligible and grants exactly one of them. A preference index, given as an age rank, lets the environment steer which legal order is taken. If the preferred entry is not eligible, the oldest eligible entry is granted. The granted operation is reported on a registered visibility port and its slot is freed at the same edge.

Top module: `mo_vis_gate`

## Requirements
- R1: After a synchronous reset the queue is empty, `full` is 0 and `vis_valid` is 0.
- R2: The queue holds up to DEPTH (8) operations. `full` is 1 exactly when DEPTH operations are pending. An enqueue offered while `full` is 1 is dropped and never becomes visible.
- R3: The class codes are 0 unordered load, 1 unordered store, 2 acquire load, 3 release store and 4 fence. No operation younger than a pending acquire is granted before that acquire.
- R4: A release is granted only when no older operation is still pending.
- R5: A fence is granted only when it is the oldest pending operation. No younger operation is granted while the fence is pending.
- R6: An older release places no constraint on a younger unordered operation or a younger acquire. Unordered operations place no constraint on each other or on a younger acquire.
- R7: `pref_idx` names an age rank, where 0 is the oldest pending operation. The entry at that rank is granted if it is eligible. Otherwise the oldest eligible entry is granted.
- R8: An operation granted at a clock edge appears on `vis_valid`, `vis_cls`, `vis_addr` and `vis_tag` for exactly the following cycle. Its slot is free after that same edge, so `full` falls at once.
- R9: No grant occurs while `grant_en` is 0. While `grant_en` is 1 and the queue is not empty, exactly one operation is granted per cycle.
- R10: Over varied preference inputs, two unordered operations can become visible in either order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Offer an operation for enqueue |
| enq_cls | input | 3 | Operation class code |
| enq_addr | input | AW | Operation address |
| enq_tag | input | TW | Operation tag |
| full | output | 1 | All slots occupied; enqueue refused |
| grant_en | input | 1 | Memory side permits one visibility this cycle |
| pref_idx | input | $clog2(DEPTH) | Preferred age rank to grant |
| vis_valid | output | 1 | An operation became visible |
| vis_cls | output | 3 | Class of the visible operation |
| vis_addr | output | AW | Address of the visible operation |
| vis_tag | output | TW | Tag of the visible operation |

## Verification
The assertions assume that only class codes 0 to 4 are presented and that `enq_valid` is never offered with undefined fields. The stimulus draws every class from that range and drives all inputs on the falling edge. The bench sweeps every ordered pair of classes under both preference ranks, then runs many eight-entry mixes in which the preference rank rotates. A ninth enqueue is offered while the queue is full in each of these mixes. The bench rebuilds the visibility order of every run and checks each older/younger pair against the acquire, release and fence rules.

// File: rtl/mo_vis_pkg.sv
package mo_vis_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    OP_LD    = 3'd0,
    OP_ST    = 3'd1,
    OP_ACQ   = 3'd2,
    OP_REL   = 3'd3,
    OP_FENCE = 3'd4
  } op_cls_e;
endpackage

// File: rtl/mo_vis_queue.sv
module mo_vis_queue
  import mo_vis_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  op_cls_e         push_cls,
  input  logic [AW-1:0]   push_addr,
  input  logic [TW-1:0]   push_tag,
  input  logic            pop,
  input  logic [IW-1:0]   pop_pos,
  output logic [CNTW-1:0] cnt,
  output logic [DEPTH-1:0] q_vld,
  output op_cls_e         q_cls  [DEPTH],
  output logic [AW-1:0]   q_addr [DEPTH],
  output logic [TW-1:0]   q_tag  [DEPTH]
);
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] wr_pos;

  // the new entry lands just above the survivors after compaction
  assign wr_pos = cnt_q - CNTW'(pop);
  assign cnt    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q - CNTW'(pop) + CNTW'(push);
  end

  genvar i;
  for (i = 0; i < DEPTH; i++) begin : g_slot
    assign q_vld[i] = CNTW'(i) < cnt_q;

    if (i < DEPTH - 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst) begin
          q_cls[i]  <= OP_LD;
          q_addr[i] <= '0;
          q_tag[i]  <= '0;
        end else if (push && CNTW'(i) == wr_pos) begin
          q_cls[i]  <= push_cls;
          q_addr[i] <= push_addr;
          q_tag[i]  <= push_tag;
        end else if (pop && IW'(i) >= pop_pos) begin
          q_cls[i]  <= q_cls[i+1];
          q_addr[i] <= q_addr[i+1];
          q_tag[i]  <= q_tag[i+1];
        end
      end
    end else begin : g_top
      always_ff @(posedge clk) begin
        if (rst) begin
          q_cls[i]  <= OP_LD;
          q_addr[i] <= '0;
          q_tag[i]  <= '0;
        end else if (push && CNTW'(i) == wr_pos) begin
          q_cls[i]  <= push_cls;
          q_addr[i] <= push_addr;
          q_tag[i]  <= push_tag;
        end
      end
    end
  end
endmodule

// File: rtl/mo_vis_elig.sv
module mo_vis_elig
  import mo_vis_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] q_vld,
  input  op_cls_e          q_cls [DEPTH],
  output logic [DEPTH-1:0] elig
);
  logic blk;
  logic serial;

  always_comb begin
    blk  = 1'b0;
    elig = '0;
    for (int i = 0; i < DEPTH; i++) begin
      // release and fence wait for every older entry to drain
      serial  = (q_cls[i] == OP_REL) || (q_cls[i] == OP_FENCE);
      elig[i] = q_vld[i] && !blk && (!serial || i == 0);
      // acquire and fence hold back everything younger
      if (q_vld[i] && (q_cls[i] == OP_ACQ || q_cls[i] == OP_FENCE))
        blk = 1'b1;
    end
  end
endmodule

// File: rtl/mo_vis_pick.sv
module mo_vis_pick #(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] elig,
  input  logic             en,
  input  logic [IW-1:0]    pref_idx,
  output logic             fire,
  output logic [IW-1:0]    pos
);
  logic [IW-1:0] old_pos;
  logic          old_any;

  always_comb begin
    old_pos = '0;
    old_any = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        old_pos = IW'(i);
        old_any = 1'b1;
      end
    end
    fire = en && old_any;
    pos  = elig[pref_idx] ? pref_idx : old_pos;
  end
endmodule

// File: rtl/mo_vis_gate.sv
module mo_vis_gate
  import mo_vis_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int TW    = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enq_valid,
  input  logic [2:0]    enq_cls,
  input  logic [AW-1:0] enq_addr,
  input  logic [TW-1:0] enq_tag,
  output logic          full,
  input  logic          grant_en,
  input  logic [IW-1:0] pref_idx,
  output logic          vis_valid,
  output logic [2:0]    vis_cls,
  output logic [AW-1:0] vis_addr,
  output logic [TW-1:0] vis_tag
);
  logic [CNTW-1:0]  cnt;
  logic [DEPTH-1:0] q_vld;
  op_cls_e          q_cls  [DEPTH];
  logic [AW-1:0]    q_addr [DEPTH];
  logic [TW-1:0]    q_tag  [DEPTH];
  logic [DEPTH-1:0] elig;
  logic             fire;
  logic [IW-1:0]    gpos;
  logic             push;

  assign full = (cnt == CNTW'(DEPTH));
  assign push = enq_valid && !full;

  mo_vis_queue #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) queue_i (
    .clk(clk), .rst(rst),
    .push(push), .push_cls(op_cls_e'(enq_cls)),
    .push_addr(enq_addr), .push_tag(enq_tag),
    .pop(fire), .pop_pos(gpos),
    .cnt(cnt), .q_vld(q_vld),
    .q_cls(q_cls), .q_addr(q_addr), .q_tag(q_tag)
  );

  mo_vis_elig #(.DEPTH(DEPTH)) elig_i (
    .q_vld(q_vld), .q_cls(q_cls), .elig(elig)
  );

  mo_vis_pick #(.DEPTH(DEPTH)) pick_i (
    .elig(elig), .en(grant_en), .pref_idx(pref_idx),
    .fire(fire), .pos(gpos)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vis_valid <= 1'b0;
      vis_cls   <= '0;
      vis_addr  <= '0;
      vis_tag   <= '0;
    end else begin
      vis_valid <= fire;
      if (fire) begin
        vis_cls  <= q_cls[gpos];
        vis_addr <= q_addr[gpos];
        vis_tag  <= q_tag[gpos];
      end
    end
  end
endmodule

// File: rtl/mo_vis_gate_chk.sv
module mo_vis_gate_chk
  import mo_vis_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [CNTW-1:0]  cnt,
  input logic [DEPTH-1:0] q_vld,
  input op_cls_e          q_cls [DEPTH],
  input logic [DEPTH-1:0] elig,
  input logic             fire,
  input logic [IW-1:0]    gpos,
  input logic             grant_en,
  input logic             vis_valid
);
  logic [DEPTH-1:0] older_hold;

  always_comb begin
    older_hold = '0;
    for (int i = 1; i < DEPTH; i++)
      older_hold[i] = older_hold[i-1] ||
        (q_vld[i-1] && (q_cls[i-1] == OP_ACQ || q_cls[i-1] == OP_FENCE));
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNTW'(DEPTH));

  // R3
  acq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> !older_hold[gpos]);

  // R4
  serial_oldest_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && (q_cls[gpos] == OP_REL || q_cls[gpos] == OP_FENCE)) |-> gpos == '0);

  // R7
  pick_elig_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> (elig[gpos] && q_vld[gpos]));

  // R9
  progress_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_en && cnt != '0) |-> fire);

  // R9
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    !grant_en |-> !fire);

  // R8
  vis_follow_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> vis_valid);

  // R8
  vis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !vis_valid);
endmodule

bind mo_vis_gate mo_vis_gate_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst(rst), .cnt(cnt), .q_vld(q_vld), .q_cls(q_cls),
  .elig(elig), .fire(fire), .gpos(gpos), .grant_en(grant_en),
  .vis_valid(vis_valid)
);

// File: tb/mo_vis_gate_tb_top.sv
module mo_vis_gate_tb_top;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int TW = 8;
  localparam int IW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enq_valid = 1'b0;
  logic [2:0]    enq_cls = '0;
  logic [AW-1:0] enq_addr = '0;
  logic [TW-1:0] enq_tag = '0;
  logic          full;
  logic          grant_en = 1'b0;
  logic [IW-1:0] pref_idx = '0;
  logic          vis_valid;
  logic [2:0]    vis_cls;
  logic [AW-1:0] vis_addr;
  logic [TW-1:0] vis_tag;

  always #2 clk = ~clk;

  mo_vis_gate #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) dut_i (
    .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_cls(enq_cls),
    .enq_addr(enq_addr), .enq_tag(enq_tag), .full(full),
    .grant_en(grant_en), .pref_idx(pref_idx), .vis_valid(vis_valid),
    .vis_cls(vis_cls), .vis_addr(vis_addr), .vis_tag(vis_tag)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // model: pending ops in age order
  int m_cls [16];
  int m_tag [16];
  int m_n = 0;
  // per-run record, indexed by tag
  int r_cls [16];
  int r_pos [16];
  int r_vis = 0;
  bit seen_fwd = 0;
  bit seen_rev = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_hold(int c);
    return c == 2 || c == 4;
  endfunction

  function automatic bit is_serial(int c);
    return c == 3 || c == 4;
  endfunction

  function automatic int exp_pick(int pref);
    bit blk = 0;
    bit e [16];
    int first = -1;
    for (int i = 0; i < m_n; i++) begin
      e[i] = !blk && (!is_serial(m_cls[i]) || i == 0);
      if (e[i] && first < 0) first = i;
      if (is_hold(m_cls[i])) blk = 1;
    end
    if (pref < m_n && e[pref]) return pref;
    return first;
  endfunction

  task automatic run_reset();
    for (int t = 0; t < 16; t++) begin
      r_pos[t] = -1;
      r_cls[t] = 0;
    end
    r_vis = 0;
  endtask

  task automatic enq(int c, int tag);
    enq_valid = 1'b1;
    enq_cls   = 3'(c);
    enq_tag   = TW'(tag);
    enq_addr  = AW'(16'h1000 + tag * 4);
    grant_en  = 1'b0;
    @(posedge clk);
    @(negedge clk);
    enq_valid = 1'b0;
    if (m_n < DEPTH) begin
      m_cls[m_n] = c;
      m_tag[m_n] = tag;
      m_n++;
      r_cls[tag] = c;
    end
    // R9: no grant with grant_en low
    chk(vis_valid == 1'b0, "R9 idle", int'(vis_valid), 0);
  endtask

  task automatic drain(int pref);
    int e;
    e = exp_pick(pref);
    grant_en = 1'b1;
    pref_idx = IW'(pref);
    @(posedge clk);
    @(negedge clk);
    grant_en = 1'b0;
    if (e < 0) begin
      chk(vis_valid == 1'b0, "R9 empty", int'(vis_valid), 0);
    end else begin
      chk(vis_valid == 1'b1, "R9 grant", int'(vis_valid), 1);
      chk(int'(vis_tag) == m_tag[e], "R7 pick", int'(vis_tag), m_tag[e]);
      chk(int'(vis_cls) == m_cls[e], "R8 cls", int'(vis_cls), m_cls[e]);
      chk(int'(vis_addr) == 16'h1000 + m_tag[e] * 4, "R8 addr",
          int'(vis_addr), 16'h1000 + m_tag[e] * 4);
      r_pos[m_tag[e]] = r_vis;
      r_vis++;
      for (int i = e; i < m_n - 1; i++) begin
        m_cls[i] = m_cls[i+1];
        m_tag[i] = m_tag[i+1];
      end
      m_n--;
    end
  endtask

  // every older/younger pair of the run against the ordering rules
  task automatic order_check(int n);
    int bad = 0;
    for (int a = 0; a < n; a++)
      for (int b = a + 1; b < n; b++)
        if (r_pos[b] < r_pos[a]) begin
          if (is_hold(r_cls[a]) || is_serial(r_cls[b])) bad++;
        end else if (r_cls[a] <= 1 && r_cls[b] <= 1) begin
          seen_fwd = 1;
        end
    for (int a = 0; a < n; a++)
      for (int b = a + 1; b < n; b++)
        if (r_pos[b] < r_pos[a] && r_cls[a] <= 1 && r_cls[b] <= 1) seen_rev = 1;
    chk(bad == 0, "R3 R4 R5 order", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1
    chk(full == 1'b0, "R1 full", int'(full), 0);
    chk(vis_valid == 1'b0, "R1 vis", int'(vis_valid), 0);
    drain(0);

    // every class pair, both preference ranks
    for (int c0 = 0; c0 < 5; c0++)
      for (int c1 = 0; c1 < 5; c1++)
        for (int p = 0; p < 2; p++) begin
          run_reset();
          enq(c0, 0);
          enq(c1, 1);
          drain(p);
          drain(p);
          chk(r_pos[0] >= 0 && r_pos[1] >= 0, "R9 both", r_vis, 2);
          if (p == 1 && c0 == 3 && c1 != 3 && c1 != 4)
            chk(r_pos[1] == 0, "R6 rel", r_pos[1], 0);
          if (p == 1 && c0 <= 1 && c1 == 2)
            chk(r_pos[1] == 0, "R6 unord acq", r_pos[1], 0);
          if (p == 1 && is_hold(c0))
            chk(r_pos[0] == 0, "R3 R5 hold", r_pos[0], 0);
          if (p == 1 && is_serial(c1))
            chk(r_pos[0] == 0, "R4 R5 wait", r_pos[0], 0);
          order_check(2);
        end

    // eight-entry mixes with a rotating preference
    for (int s = 0; s < 40; s++) begin
      run_reset();
      for (int k = 0; k < DEPTH; k++) begin
        chk(full == 1'b0, "R2 not full", int'(full), 0);
        enq((s * 3 + k * k + k * s + (s / 7) * k) % 5, k);
      end
      chk(full == 1'b1, "R2 full", int'(full), 1);
      enq(1, 8);
      chk(full == 1'b1, "R2 still full", int'(full), 1);
      for (int d = 0; d < DEPTH; d++) begin
        drain((s + d * 3 + s / 5) % DEPTH);
        if (d == 0) chk(full == 1'b0, "R8 slot freed", int'(full), 0);
      end
      chk(r_pos[8] == -1, "R2 dropped", r_pos[8], -1);
      chk(r_vis == DEPTH, "R2 count", r_vis, DEPTH);
      order_check(DEPTH);
      drain(s % DEPTH);
    end

    // R10
    chk(seen_fwd, "R10 in order", int'(seen_fwd), 1);
    chk(seen_rev, "R10 reversed", int'(seen_rev), 1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule